// File: doc/BRIEF.md
# Address Security Attribution Unit

This block classifies any 32-bit address as Secure, Non-secure or Non-secure-Callable (a callable form of Secure memory). Software programs a small table of address windows through a plain register port. Each window has a base, an inclusive limit, an enable bit and a callable flag. A control register holds a global enable and a bit that makes the disabled unit report everything as Non-secure.

The lookup is purely combinational. The address and an optional attribution from elsewhere in the system go in. The final attribute, the matching window number and a multiple-hit flag come out in the same cycle. The lookup has no flow control and cannot back-pressure: a new address may be presented every cycle. Register writes take effect at the next clock edge. Reads are combinational.

Top module: `addr_attr_unit`

## Requirements
- R1: After reset the unit is disabled with the all-non-secure bit clear. The region select and every region's base, limit, enable and callable fields read back as zero, and every lookup reports Secure with no hit.
- R2: While the global enable is clear, no region takes part in the lookup. The region-hit and multiple-hit outputs stay low. The unit result is Non-secure if control bit 1 is set and Secure otherwise.
- R3: While enabled, an address that falls in no enabled region resolves to Secure, with region-hit low.
- R4: While enabled, an address that falls in exactly one enabled region with callable flag 0 resolves to Non-secure (attribute code 0). Region-hit is high and the region number output gives that region. When region-hit is low, the region number output is 0.
- R5: An address that falls in exactly one enabled region with callable flag 1 resolves to Non-secure-Callable (code 1).
- R6: Regions work on 32-byte blocks. An address is inside when its bits [31:5] lie between the base and the limit, both ends included. Address bits [4:0] have no effect, and the topmost block of the 4 GB space can be covered.
- R7: If two or more enabled regions contain the address, the result is Secure (code 2), the multiple-hit flag is high and region-hit is low.
- R8: A region whose enable bit is clear never matches, even when the address lies inside its window.
- R9: When the external attribution input is marked present, the final attribute is the more secure of the unit result and that input. The order is Secure (2) > Non-secure-Callable (1) > Non-secure (0), and input code 3 counts as Secure. When the input is not present, its value has no effect.
- R10: Register map by cfg_addr: 0 control (bit 0 enable, bit 1 all-non-secure); 1 region select (low 3 bits, wider values wrap); 2 base (bits [31:5]); 3 limit (bits [31:5], bit 1 callable, bit 0 enable). Base and limit access the selected region. Unused bits read as zero.
- R11: While the unit is enabled, the all-non-secure bit has no effect on any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the register at cfg_addr |
| lk_addr | input | 32 | Address to classify |
| ext_present | input | 1 | External attribution input is valid |
| ext_attr | input | 2 | External attribution code |
| lk_attr | output | 2 | Final attribute: 0 Non-secure, 1 Non-secure-Callable, 2 Secure |
| lk_region_hit | output | 1 | Exactly one enabled region matched |
| lk_region | output | 3 | Number of the matching region |
| lk_multi_hit | output | 1 | More than one enabled region matched |

## Verification
The bench builds the block with its default parameters: eight regions, a 32-bit address and 32-byte blocks. This makes the 3-bit region select small enough to show wrap-around when 0xF is written. It also lets a region sit on the very last block below 4 GB. With eight windows, the bench can overlap two regions, leave one programmed but disabled, and still keep callable and plain regions side by side. Every lookup is then compared against a reference model built from the requirements.

// File: rtl/attr_pkg.sv
package attr_pkg;
  typedef enum logic [1:0] {
    ATTR_NS  = 2'd0,
    ATTR_NSC = 2'd1,
    ATTR_S   = 2'd2
  } attr_e;

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_SEL   = 2'd1;
  localparam logic [1:0] REG_BASE  = 2'd2;
  localparam logic [1:0] REG_LIMIT = 2'd3;

  // Map any 2-bit code onto the three legal attributes; code 3 counts as Secure.
  function automatic attr_e attr_clean(input logic [1:0] code);
    if (code >= 2'd2) return ATTR_S;
    else if (code == 2'd1) return ATTR_NSC;
    else return ATTR_NS;
  endfunction

  function automatic attr_e attr_stronger(input attr_e a, input attr_e b);
    return (a >= b) ? a : b;
  endfunction
endpackage

// File: rtl/region_cfg_regs.sv
module region_cfg_regs #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int GRAN_LOG2   = 5,
  localparam int SEL_W      = $clog2(NUM_REGIONS),
  localparam int BLK_W      = ADDR_W - GRAN_LOG2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [1:0]                        cfg_addr,
  input  logic [ADDR_W-1:0]                 cfg_wdata,
  output logic [ADDR_W-1:0]                 cfg_rdata,
  output logic                              unit_en,
  output logic                              all_ns,
  output logic [SEL_W-1:0]                  region_sel,
  output logic [NUM_REGIONS-1:0][BLK_W-1:0] base_q,
  output logic [NUM_REGIONS-1:0][BLK_W-1:0] limit_q,
  output logic [NUM_REGIONS-1:0]            reg_en_q,
  output logic [NUM_REGIONS-1:0]            reg_nsc_q
);
  import attr_pkg::*;

  localparam int PAD_W = GRAN_LOG2 - 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_en    <= 1'b0;
      all_ns     <= 1'b0;
      region_sel <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == REG_CTRL) begin
        unit_en <= cfg_wdata[0];
        all_ns  <= cfg_wdata[1];
      end
      if (cfg_addr == REG_SEL) region_sel <= cfg_wdata[SEL_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic sel_hit;
    assign sel_hit = (region_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]    <= '0;
        limit_q[g]   <= '0;
        reg_en_q[g]  <= 1'b0;
        reg_nsc_q[g] <= 1'b0;
      end else if (cfg_we && sel_hit) begin
        if (cfg_addr == REG_BASE) base_q[g] <= cfg_wdata[ADDR_W-1:GRAN_LOG2];
        if (cfg_addr == REG_LIMIT) begin
          limit_q[g]   <= cfg_wdata[ADDR_W-1:GRAN_LOG2];
          reg_nsc_q[g] <= cfg_wdata[1];
          reg_en_q[g]  <= cfg_wdata[0];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      REG_CTRL:  cfg_rdata = {{(ADDR_W-2){1'b0}}, all_ns, unit_en};
      REG_SEL:   cfg_rdata = {{(ADDR_W-SEL_W){1'b0}}, region_sel};
      REG_BASE:  cfg_rdata = {base_q[region_sel], {GRAN_LOG2{1'b0}}};
      REG_LIMIT: cfg_rdata = {limit_q[region_sel], {PAD_W{1'b0}},
                              reg_nsc_q[region_sel], reg_en_q[region_sel]};
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/region_match.sv
module region_match #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int GRAN_LOG2   = 5,
  localparam int BLK_W      = ADDR_W - GRAN_LOG2
) (
  input  logic [ADDR_W-1:0]                 lk_addr,
  input  logic [NUM_REGIONS-1:0][BLK_W-1:0] base_q,
  input  logic [NUM_REGIONS-1:0][BLK_W-1:0] limit_q,
  input  logic [NUM_REGIONS-1:0]            reg_en_q,
  output logic [NUM_REGIONS-1:0]            hit_vec
);
  logic [BLK_W-1:0] blk;
  assign blk = lk_addr[ADDR_W-1:GRAN_LOG2];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    logic above_base;
    logic below_limit;
    assign above_base  = (blk >= base_q[g]);
    assign below_limit = (blk <= limit_q[g]);
    assign hit_vec[g]  = reg_en_q[g] && above_base && below_limit;
  end
endmodule

// File: rtl/attr_resolve.sv
module attr_resolve #(
  parameter int NUM_REGIONS = 8,
  localparam int SEL_W      = $clog2(NUM_REGIONS),
  localparam int CNT_W      = $clog2(NUM_REGIONS + 1)
) (
  input  logic                   unit_en,
  input  logic                   all_ns,
  input  logic [NUM_REGIONS-1:0] hit_vec,
  input  logic [NUM_REGIONS-1:0] reg_nsc_q,
  input  logic                   ext_present,
  input  logic [1:0]             ext_attr,
  output logic [1:0]             lk_attr,
  output logic                   lk_region_hit,
  output logic [SEL_W-1:0]       lk_region,
  output logic                   lk_multi_hit
);
  import attr_pkg::*;

  logic [CNT_W-1:0] hit_cnt;
  logic [SEL_W-1:0] first_idx;
  logic             first_nsc;
  attr_e            unit_res;
  attr_e            final_res;

  always_comb begin
    hit_cnt   = '0;
    first_idx = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_cnt   = hit_cnt + CNT_W'(1);
        first_idx = SEL_W'(i);
      end
    end
    first_nsc = reg_nsc_q[first_idx];
  end

  always_comb begin
    lk_region_hit = 1'b0;
    lk_multi_hit  = 1'b0;
    lk_region     = '0;
    if (!unit_en) begin
      unit_res = all_ns ? ATTR_NS : ATTR_S;
    end else if (hit_cnt == '0) begin
      unit_res = ATTR_S;
    end else if (hit_cnt == CNT_W'(1)) begin
      unit_res      = first_nsc ? ATTR_NSC : ATTR_NS;
      lk_region_hit = 1'b1;
      lk_region     = first_idx;
    end else begin
      unit_res     = ATTR_S;
      lk_multi_hit = 1'b1;
    end
    final_res = ext_present ? attr_stronger(unit_res, attr_clean(ext_attr)) : unit_res;
    lk_attr   = final_res;
  end
endmodule

// File: rtl/addr_attr_unit.sv
module addr_attr_unit #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int GRAN_LOG2   = 5,
  localparam int SEL_W      = $clog2(NUM_REGIONS),
  localparam int BLK_W      = ADDR_W - GRAN_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              ext_present,
  input  logic [1:0]        ext_attr,
  output logic [1:0]        lk_attr,
  output logic              lk_region_hit,
  output logic [SEL_W-1:0]  lk_region,
  output logic              lk_multi_hit
);
  logic                              unit_en;
  logic                              all_ns;
  logic [SEL_W-1:0]                  region_sel;
  logic [NUM_REGIONS-1:0][BLK_W-1:0] base_q;
  logic [NUM_REGIONS-1:0][BLK_W-1:0] limit_q;
  logic [NUM_REGIONS-1:0]            reg_en_q;
  logic [NUM_REGIONS-1:0]            reg_nsc_q;
  logic [NUM_REGIONS-1:0]            hit_vec;

  region_cfg_regs #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .unit_en    (unit_en),
    .all_ns     (all_ns),
    .region_sel (region_sel),
    .base_q     (base_q),
    .limit_q    (limit_q),
    .reg_en_q   (reg_en_q),
    .reg_nsc_q  (reg_nsc_q)
  );

  region_match #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_match (
    .lk_addr  (lk_addr),
    .base_q   (base_q),
    .limit_q  (limit_q),
    .reg_en_q (reg_en_q),
    .hit_vec  (hit_vec)
  );

  attr_resolve #(.NUM_REGIONS(NUM_REGIONS)) u_resolve (
    .unit_en       (unit_en),
    .all_ns        (all_ns),
    .hit_vec       (hit_vec),
    .reg_nsc_q     (reg_nsc_q),
    .ext_present   (ext_present),
    .ext_attr      (ext_attr),
    .lk_attr       (lk_attr),
    .lk_region_hit (lk_region_hit),
    .lk_region     (lk_region),
    .lk_multi_hit  (lk_multi_hit)
  );
endmodule

// File: rtl/addr_attr_unit_chk.sv
module addr_attr_unit_chk #(
  parameter int NUM_REGIONS = 8,
  localparam int SEL_W      = $clog2(NUM_REGIONS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic             unit_en,
  input logic             all_ns,
  input logic [SEL_W-1:0] region_sel,
  input logic             ext_present,
  input logic [1:0]       ext_attr,
  input logic [1:0]       lk_attr,
  input logic             lk_region_hit,
  input logic [SEL_W-1:0] lk_region,
  input logic             lk_multi_hit
);
  assert_off_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en |-> (!lk_region_hit && !lk_multi_hit));

  assert_off_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unit_en && !ext_present) |-> (lk_attr == (all_ns ? 2'd0 : 2'd2)));

  assert_miss_secure_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && !lk_region_hit) |-> (lk_attr == 2'd2));

  assert_idx_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_region_hit |-> (lk_region == '0));

  assert_multi_secure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi_hit |-> (lk_attr == 2'd2 && !lk_region_hit));

  assert_ext_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_present && ext_attr[1]) |-> (lk_attr == 2'd2));

  assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == 2'd1) |=> $stable(region_sel));
endmodule

bind addr_attr_unit addr_attr_unit_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .cfg_addr      (cfg_addr),
  .unit_en       (unit_en),
  .all_ns        (all_ns),
  .region_sel    (region_sel),
  .ext_present   (ext_present),
  .ext_attr      (ext_attr),
  .lk_attr       (lk_attr),
  .lk_region_hit (lk_region_hit),
  .lk_region     (lk_region),
  .lk_multi_hit  (lk_multi_hit)
);

// File: tb/tb_addr_attr_unit.sv
module tb_addr_attr_unit;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] lk_addr = '0;
  logic        ext_present = 1'b0;
  logic [1:0]  ext_attr = 2'd0;
  logic [1:0]  lk_attr;
  logic        lk_region_hit;
  logic [2:0]  lk_region;
  logic        lk_multi_hit;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addr_attr_unit dut (.*);

  typedef struct {
    logic [1:0] attr;
    logic       hit;
    logic [2:0] idx;
    logic       multi;
    string      req;
  } exp_t;

  exp_t sb[$];

  // reference model state, following the requirements
  bit        m_en, m_allns;
  bit [26:0] m_base [NR];
  bit [26:0] m_lim  [NR];
  bit        m_ren  [NR];
  bit        m_nsc  [NR];

  function automatic exp_t model(input logic [31:0] a, input bit ep, input logic [1:0] ea, input string req);
    exp_t e;
    int n = 0;
    int who = 0;
    logic [1:0] u;
    logic [1:0] x;
    for (int i = 0; i < NR; i++)
      if (m_ren[i] && a[31:5] >= m_base[i] && a[31:5] <= m_lim[i]) begin
        if (n == 0) who = i;
        n++;
      end
    e.hit = 0; e.multi = 0; e.idx = 0; e.req = req;
    if (!m_en) u = m_allns ? 2'd0 : 2'd2;
    else if (n == 0) u = 2'd2;
    else if (n == 1) begin u = m_nsc[who] ? 2'd1 : 2'd0; e.hit = 1; e.idx = 3'(who); end
    else begin u = 2'd2; e.multi = 1; end
    x = (ea == 2'd3) ? 2'd2 : ea;
    e.attr = (ep && x > u) ? x : u;
    return e;
  endfunction

  task automatic lookup(input logic [31:0] a, input bit ep, input logic [1:0] ea, input string req);
    @(posedge clk); #1;
    lk_addr = a; ext_present = ep; ext_attr = ea;
    sb.push_back(model(a, ep, ea, req));
    @(negedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (lk_attr !== e.attr || lk_region_hit !== e.hit || lk_region !== e.idx || lk_multi_hit !== e.multi) begin
        fails++;
        $display("FAIL %s addr=%h: got attr=%0d hit=%0d idx=%0d multi=%0d, expected attr=%0d hit=%0d idx=%0d multi=%0d",
                 e.req, lk_addr, lk_attr, lk_region_hit, lk_region, lk_multi_hit, e.attr, e.hit, e.idx, e.multi);
      end
    end
  end

  task automatic wr(input logic [1:0] ad, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] ad, input logic [31:0] expv, input string req);
    @(posedge clk); #1;
    cfg_addr = ad;
    @(negedge clk);
    checks++;
    if (cfg_rdata !== expv) begin
      fails++;
      $display("FAIL %s reg %0d: got %h expected %h", req, ad, cfg_rdata, expv);
    end
  endtask

  task automatic set_ctrl(input bit en, input bit allns);
    wr(2'd0, {30'd0, allns, en});
    m_en = en; m_allns = allns;
  endtask

  task automatic set_region(input int idx, input logic [31:0] b, input logic [31:0] l, input bit en, input bit nsc);
    wr(2'd1, 32'(idx));
    wr(2'd2, b);
    wr(2'd3, {l[31:5], 3'b000, nsc, en});
    m_base[idx] = b[31:5]; m_lim[idx] = l[31:5]; m_ren[idx] = en; m_nsc[idx] = nsc;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    m_en = 0; m_allns = 0;
    for (int i = 0; i < NR; i++) begin m_base[i] = 0; m_lim[i] = 0; m_ren[i] = 0; m_nsc[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd_check(2'd0, 32'h0, "R1");
    rd_check(2'd1, 32'h0, "R1");
    rd_check(2'd2, 32'h0, "R1");
    rd_check(2'd3, 32'h0, "R1");
    lookup(32'h1234_5678, 0, 2'd0, "R1");

    // R2: disabled, all-non-secure set; programmed region must not take part
    set_ctrl(0, 1);
    rd_check(2'd0, 32'h2, "R10");
    lookup(32'h0000_0040, 0, 2'd0, "R2");
    set_region(0, 32'h1000_0000, 32'h1000_0FE0, 1, 0);
    lookup(32'h1000_0100, 0, 2'd0, "R2");

    // R10: readback, dropped low bits, select wrap
    rd_check(2'd1, 32'h0, "R10");
    rd_check(2'd2, 32'h1000_0000, "R10");
    rd_check(2'd3, 32'h1000_0FE1, "R10");
    wr(2'd2, 32'h2000_001F);
    rd_check(2'd2, 32'h2000_0000, "R10");
    wr(2'd2, 32'h1000_0000);

    set_region(1, 32'h2000_0000, 32'h2000_03E0, 1, 1);
    set_region(2, 32'h3000_0000, 32'h3000_FFE0, 0, 0);
    set_region(3, 32'h1000_0800, 32'h1000_1FE0, 1, 0);
    wr(2'd1, 32'h0000_000F);
    rd_check(2'd1, 32'h7, "R10");
    wr(2'd2, 32'hFFFF_FFE0);
    wr(2'd3, 32'hFFFF_FFE3);
    m_base[7] = 27'h7FF_FFFF; m_lim[7] = 27'h7FF_FFFF; m_ren[7] = 1; m_nsc[7] = 1;
    rd_check(2'd3, 32'hFFFF_FFE3, "R10");
    wr(2'd1, 32'h1);
    rd_check(2'd3, 32'h2000_03E3, "R10");

    // enabled with all-non-secure still set
    set_ctrl(1, 1);
    lookup(32'h0000_0000, 0, 2'd0, "R3_R11");
    lookup(32'h1000_0000, 0, 2'd0, "R4");
    lookup(32'h1000_07FF, 0, 2'd0, "R6");
    lookup(32'h1000_07E0, 0, 2'd0, "R6");
    lookup(32'h1000_0800, 0, 2'd0, "R7");
    lookup(32'h1000_0FFF, 0, 2'd0, "R7");
    lookup(32'h1000_1000, 0, 2'd0, "R4");
    lookup(32'h1000_1FFF, 0, 2'd0, "R6");
    lookup(32'h1000_2000, 0, 2'd0, "R6");
    lookup(32'h0FFF_FFFF, 0, 2'd0, "R6");
    lookup(32'h2000_0010, 0, 2'd0, "R5");
    lookup(32'h2000_03FF, 0, 2'd0, "R5");
    lookup(32'h2000_0400, 0, 2'd0, "R3");
    lookup(32'h3000_0100, 0, 2'd0, "R8");
    lookup(32'hFFFF_FFFF, 0, 2'd0, "R5_R6");
    lookup(32'hFFFF_FFDF, 0, 2'd0, "R6");

    // R9: external attribution
    lookup(32'h1000_0000, 1, 2'd1, "R9");
    lookup(32'h1000_0000, 1, 2'd2, "R9");
    lookup(32'h1000_0000, 1, 2'd3, "R9");
    lookup(32'h1000_0000, 1, 2'd0, "R9");
    lookup(32'h1000_0000, 0, 2'd2, "R9");
    lookup(32'h2000_0010, 1, 2'd0, "R9");
    lookup(32'h0000_0100, 1, 2'd0, "R9");

    // R11: all-non-secure cleared while enabled gives identical results
    set_ctrl(1, 0);
    lookup(32'h1000_0000, 0, 2'd0, "R11");
    lookup(32'h0000_0000, 0, 2'd0, "R11");

    // R2: disabled without all-non-secure
    set_ctrl(0, 0);
    lookup(32'h1000_0000, 0, 2'd0, "R2");
    lookup(32'h1000_0000, 1, 2'd0, "R2");
    set_ctrl(0, 1);
    lookup(32'h1000_0000, 1, 2'd1, "R9");

    // R8: enabling region 2 makes it match
    set_ctrl(1, 0);
    set_region(2, 32'h3000_0000, 32'h3000_FFE0, 1, 0);
    lookup(32'h3000_0100, 0, 2'd0, "R8");

    @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule